// File: doc/BRIEF.md
# Load Miss Buffer

This block holds data-cache load misses while memory works on them, so that the cache can keep accepting loads after a miss. Each missed load is written into a circular queue together with its address, the physical register it will write and the reorder-buffer slot it belongs to. The queue then asks memory for the lines one entry at a time, in the order the misses arrived. Memory answers each request at once with a transaction tag. Later it delivers the data with that same tag. The buffer compares the tag against every waiting entry and broadcasts the matching load on a result bus.

Three pointers walk the queue. The allocation pointer (tail) marks where the next miss goes. The request pointer marks the oldest entry not yet sent to memory. The retire pointer marks the oldest entry still held. Data can come back in any order, so entries are freed out of order. The retire pointer then steps over freed entries one per cycle, and only slots behind it can be used again. Each pointer has a wrap bit so that a full queue and an empty queue can be told apart.

Each slot runs a small state machine with three states:
- SLOT_IDLE: the slot is free.
- SLOT_ISSUE: the slot is allocated and its request has not been accepted yet.
- SLOT_PENDING: memory has accepted the request and the slot is waiting for data.

The transitions are:
- *alloc*: SLOT_IDLE to SLOT_ISSUE.
- *accept*: SLOT_ISSUE to SLOT_PENDING.
- *complete*: SLOT_PENDING to SLOT_IDLE.
- *flush*: any state to SLOT_IDLE.

The queue as a whole is in one of three occupancy states: OCC_EMPTY, OCC_PARTIAL or OCC_FULL. When the queue is full, the load-store queue must stop sending loads. A branch mispredict empties the whole buffer.

Top module: `load_miss_buffer`

## Requirements
- R1: After reset, `full`, `mem_req_valid`, `res_valid` and `lsq_one_load` are all low.
- R2: Memory requests appear on `mem_req_addr` in the order the loads were accepted on the allocation port. This order holds across pointer wrap-around.
- R3: A request that sees `mem_resp_tag` equal to zero is not accepted. `mem_req_valid` stays high with the same address in the next cycle.
- R4: If `mem_data_tag` is nonzero and equals the tag stored for a waiting entry, then on the next clock edge `res_valid` rises. On that edge `res_data` takes the value of `mem_data`, and `res_preg`/`res_rob` take the values stored with that load. At most one load completes per cycle.
- R5: A `mem_data_tag` that is zero, or that matches no waiting entry, produces no result.
- R6: `full` rises after DEPTH loads are held. An allocation offered while `full` is high is dropped and never reaches memory.
- R7: Slots are reused only in allocation order. When a younger entry completes, `full` stays high. When the oldest entry completes, `full` falls on the second clock edge after its data tag was presented.
- R8: `flush` empties the buffer. After the edge it is sampled on, `full`, `mem_req_valid` and `res_valid` are low. Data returned later for a squashed entry produces no result. The next allocation is requested first.
- R9: `lsq_one_load` is high exactly in the cycles in which a completed load is on the result bus.
- R10: `mem_req_valid` is low once every held entry has been accepted by memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | A missed load is offered |
| alloc_addr | input | ADDR_W | Address of the missed load |
| alloc_preg | input | PREG_W | Destination physical register |
| alloc_rob | input | ROB_W | Reorder-buffer slot of the load |
| full | output | 1 | Every slot is held; stop issuing loads |
| lsq_one_load | output | 1 | A miss completes this cycle; the load-store queue may issue only one load |
| mem_req_valid | output | 1 | A request is presented to memory |
| mem_req_addr | output | ADDR_W | Address of the presented request |
| mem_resp_tag | input | MTAG_W | Same-cycle transaction tag; zero means retry |
| mem_data_tag | input | MTAG_W | Tag of returning data; zero means none |
| mem_data | input | DATA_W | Returning data |
| flush | input | 1 | Mispredict squash of all entries |
| res_valid | output | 1 | A completed load is broadcast |
| res_data | output | DATA_W | Data of the completed load |
| res_preg | output | PREG_W | Destination register of the completed load |
| res_rob | output | ROB_W | Reorder-buffer slot of the completed load |

## Verification
The bench runs batches of every size from one up to DEPTH, one after another, so the pointers wrap several times. Data for a batch is returned either oldest-first or youngest-first. In-order return tests the retire pointer on its simple path. Reverse return forces entries to be freed out of order, and it would expose any tag match that looks only at the oldest entry.

Every request is first refused with a zero tag, which separates retry from acceptance. A full queue is completed youngest-first, then oldest-first. This shows apart a `full` flag that follows the count of live entries from one that follows the retire pointer. Stray tags, and tags of squashed entries, must produce nothing.

// File: rtl/lmb_pkg.sv
package lmb_pkg;

    typedef enum logic [1:0] {
        SLOT_IDLE    = 2'd0,
        SLOT_ISSUE   = 2'd1,
        SLOT_PENDING = 2'd2
    } slot_state_e;

    typedef enum logic [1:0] {
        OCC_EMPTY   = 2'd0,
        OCC_PARTIAL = 2'd1,
        OCC_FULL    = 2'd2
    } occ_e;

endpackage

// File: rtl/lmb_slot.sv
module lmb_slot
    import lmb_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int PREG_W = 6,
    parameter int ROB_W  = 5,
    parameter int MTAG_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              alloc_we,
    input  logic [ADDR_W-1:0] alloc_addr,
    input  logic [PREG_W-1:0] alloc_preg,
    input  logic [ROB_W-1:0]  alloc_rob,
    input  logic              accept,
    input  logic [MTAG_W-1:0] accept_tag,
    input  logic [MTAG_W-1:0] data_tag,
    output slot_state_e       state,
    output logic [ADDR_W-1:0] addr,
    output logic [PREG_W-1:0] preg,
    output logic [ROB_W-1:0]  rob,
    output logic              hit
);

    slot_state_e       state_q, state_d;
    logic [MTAG_W-1:0] tag_q;

    // tag match only for a slot that is waiting for data
    assign hit = (state_q == SLOT_PENDING) && (data_tag != '0) && (data_tag == tag_q);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_IDLE:    if (alloc_we) state_d = SLOT_ISSUE;
            SLOT_ISSUE:   if (accept)   state_d = SLOT_PENDING;
            SLOT_PENDING: if (hit)      state_d = SLOT_IDLE;
            default:                    state_d = SLOT_IDLE;
        endcase
        if (flush) state_d = SLOT_IDLE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SLOT_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr  <= '0;
            preg  <= '0;
            rob   <= '0;
            tag_q <= '0;
        end else begin
            if (alloc_we) begin
                addr <= alloc_addr;
                preg <= alloc_preg;
                rob  <= alloc_rob;
            end
            if (accept) tag_q <= accept_tag;
        end
    end

    assign state = state_q;

endmodule

// File: rtl/lmb_ptr_ctl.sv
module lmb_ptr_ctl
    import lmb_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             alloc_fire,
    input  logic             issue_fire,
    input  logic             retire_fire,
    output logic [IDX_W-1:0] tail_idx,
    output logic [IDX_W-1:0] req_idx,
    output logic [IDX_W-1:0] ret_idx,
    output occ_e             occ
);

    localparam int PTR_W = IDX_W + 1;

    logic [PTR_W-1:0] tail_q, req_q, ret_q;

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            tail_q <= '0;
            req_q  <= '0;
            ret_q  <= '0;
        end else begin
            if (alloc_fire)  tail_q <= tail_q + PTR_W'(1);
            if (issue_fire)  req_q  <= req_q  + PTR_W'(1);
            if (retire_fire) ret_q  <= ret_q  + PTR_W'(1);
        end
    end

    always_comb begin
        if (tail_q == ret_q)
            occ = OCC_EMPTY;
        else if ((tail_q[IDX_W-1:0] == ret_q[IDX_W-1:0]) && (tail_q[IDX_W] != ret_q[IDX_W]))
            occ = OCC_FULL;
        else
            occ = OCC_PARTIAL;
    end

    assign tail_idx = tail_q[IDX_W-1:0];
    assign req_idx  = req_q[IDX_W-1:0];
    assign ret_idx  = ret_q[IDX_W-1:0];

endmodule

// File: rtl/lmb_result.sv
module lmb_result #(
    parameter int DEPTH  = 8,
    parameter int PREG_W = 6,
    parameter int ROB_W  = 5,
    parameter int DATA_W = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush,
    input  logic [DEPTH-1:0]             hit_vec,
    input  logic [DEPTH-1:0][PREG_W-1:0] slot_preg,
    input  logic [DEPTH-1:0][ROB_W-1:0]  slot_rob,
    input  logic [DATA_W-1:0]            data_in,
    output logic                         res_valid,
    output logic [DATA_W-1:0]            res_data,
    output logic [PREG_W-1:0]            res_preg,
    output logic [ROB_W-1:0]             res_rob
);

    logic              any_hit;
    logic [PREG_W-1:0] sel_preg;
    logic [ROB_W-1:0]  sel_rob;

    // at most one slot hits, so an OR of the selected fields is enough
    always_comb begin
        any_hit  = |hit_vec;
        sel_preg = '0;
        sel_rob  = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (hit_vec[i]) begin
                sel_preg = sel_preg | slot_preg[i];
                sel_rob  = sel_rob  | slot_rob[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_data  <= '0;
            res_preg  <= '0;
            res_rob   <= '0;
        end else begin
            res_valid <= any_hit && !flush;
            if (any_hit) begin
                res_data <= data_in;
                res_preg <= sel_preg;
                res_rob  <= sel_rob;
            end
        end
    end

endmodule

// File: rtl/load_miss_buffer.sv
module load_miss_buffer
    import lmb_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 32,
    parameter int PREG_W = 6,
    parameter int ROB_W  = 5,
    parameter int MTAG_W = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_valid,
    input  logic [ADDR_W-1:0] alloc_addr,
    input  logic [PREG_W-1:0] alloc_preg,
    input  logic [ROB_W-1:0]  alloc_rob,
    output logic              full,
    output logic              lsq_one_load,
    output logic              mem_req_valid,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic [MTAG_W-1:0] mem_resp_tag,
    input  logic [MTAG_W-1:0] mem_data_tag,
    input  logic [DATA_W-1:0] mem_data,
    input  logic              flush,
    output logic              res_valid,
    output logic [DATA_W-1:0] res_data,
    output logic [PREG_W-1:0] res_preg,
    output logic [ROB_W-1:0]  res_rob
);

    localparam int IDX_W = $clog2(DEPTH);

    logic [IDX_W-1:0] tail_idx, req_idx, ret_idx;
    occ_e             occ;
    logic             empty;
    logic             alloc_fire, issue_fire, retire_fire;

    slot_state_e                 slot_state [DEPTH];
    logic [DEPTH-1:0][ADDR_W-1:0] slot_addr;
    logic [DEPTH-1:0][PREG_W-1:0] slot_preg;
    logic [DEPTH-1:0][ROB_W-1:0]  slot_rob;
    logic [DEPTH-1:0]             hit_vec;

    assign full  = (occ == OCC_FULL);
    assign empty = (occ == OCC_EMPTY);

    assign alloc_fire    = alloc_valid && !full && !flush;
    assign mem_req_valid = (slot_state[req_idx] == SLOT_ISSUE);
    assign mem_req_addr  = slot_addr[req_idx];
    assign issue_fire    = mem_req_valid && (mem_resp_tag != '0) && !flush;
    assign retire_fire   = !empty && (slot_state[ret_idx] == SLOT_IDLE) && !flush;

    lmb_ptr_ctl #(
        .DEPTH (DEPTH),
        .IDX_W (IDX_W)
    ) ptr_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .flush       (flush),
        .alloc_fire  (alloc_fire),
        .issue_fire  (issue_fire),
        .retire_fire (retire_fire),
        .tail_idx    (tail_idx),
        .req_idx     (req_idx),
        .ret_idx     (ret_idx),
        .occ         (occ)
    );

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        lmb_slot #(
            .ADDR_W (ADDR_W),
            .PREG_W (PREG_W),
            .ROB_W  (ROB_W),
            .MTAG_W (MTAG_W)
        ) slot_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .flush      (flush),
            .alloc_we   (alloc_fire && (tail_idx == IDX_W'(g))),
            .alloc_addr (alloc_addr),
            .alloc_preg (alloc_preg),
            .alloc_rob  (alloc_rob),
            .accept     (issue_fire && (req_idx == IDX_W'(g))),
            .accept_tag (mem_resp_tag),
            .data_tag   (mem_data_tag),
            .state      (slot_state[g]),
            .addr       (slot_addr[g]),
            .preg       (slot_preg[g]),
            .rob        (slot_rob[g]),
            .hit        (hit_vec[g])
        );
    end

    lmb_result #(
        .DEPTH  (DEPTH),
        .PREG_W (PREG_W),
        .ROB_W  (ROB_W),
        .DATA_W (DATA_W)
    ) res_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .hit_vec   (hit_vec),
        .slot_preg (slot_preg),
        .slot_rob  (slot_rob),
        .data_in   (mem_data),
        .res_valid (res_valid),
        .res_data  (res_data),
        .res_preg  (res_preg),
        .res_rob   (res_rob)
    );

    assign lsq_one_load = res_valid;

endmodule

// File: rtl/lmb_checker.sv
module lmb_checker #(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 32,
    parameter int MTAG_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              flush,
    input logic              full,
    input logic              mem_req_valid,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic [MTAG_W-1:0] mem_resp_tag,
    input logic [MTAG_W-1:0] mem_data_tag,
    input logic              res_valid,
    input logic [DEPTH-1:0]  hit_vec
);

    // R8: a squash leaves nothing behind
    p_flush_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!mem_req_valid && !full && !res_valid));

    // R4: a broadcast always follows a nonzero data tag
    p_result_needs_tag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> ($past(mem_data_tag) != '0));

    // R3: a refused request is presented again unchanged
    p_retry_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && (mem_resp_tag == '0) && !flush) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R4: one completion per cycle at most
    p_single_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

endmodule

bind load_miss_buffer lmb_checker #(
    .DEPTH  (DEPTH),
    .ADDR_W (ADDR_W),
    .MTAG_W (MTAG_W)
) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .flush         (flush),
    .full          (full),
    .mem_req_valid (mem_req_valid),
    .mem_req_addr  (mem_req_addr),
    .mem_resp_tag  (mem_resp_tag),
    .mem_data_tag  (mem_data_tag),
    .res_valid     (res_valid),
    .hit_vec       (hit_vec)
);

// File: tb/load_miss_buffer_tb_top.sv
module load_miss_buffer_tb_top;

    localparam int DEPTH  = 8;
    localparam int ADDR_W = 32;
    localparam int PREG_W = 6;
    localparam int ROB_W  = 5;
    localparam int MTAG_W = 4;
    localparam int DATA_W = 32;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              alloc_valid;
    logic [ADDR_W-1:0] alloc_addr;
    logic [PREG_W-1:0] alloc_preg;
    logic [ROB_W-1:0]  alloc_rob;
    logic              full;
    logic              lsq_one_load;
    logic              mem_req_valid;
    logic [ADDR_W-1:0] mem_req_addr;
    logic [MTAG_W-1:0] mem_resp_tag;
    logic [MTAG_W-1:0] mem_data_tag;
    logic [DATA_W-1:0] mem_data;
    logic              flush;
    logic              res_valid;
    logic [DATA_W-1:0] res_data;
    logic [PREG_W-1:0] res_preg;
    logic [ROB_W-1:0]  res_rob;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    load_miss_buffer #(
        .DEPTH (DEPTH), .ADDR_W (ADDR_W), .PREG_W (PREG_W),
        .ROB_W (ROB_W), .MTAG_W (MTAG_W), .DATA_W (DATA_W)
    ) dut_i (
        .clk (clk), .rst_n (rst_n),
        .alloc_valid (alloc_valid), .alloc_addr (alloc_addr),
        .alloc_preg (alloc_preg), .alloc_rob (alloc_rob),
        .full (full), .lsq_one_load (lsq_one_load),
        .mem_req_valid (mem_req_valid), .mem_req_addr (mem_req_addr),
        .mem_resp_tag (mem_resp_tag), .mem_data_tag (mem_data_tag),
        .mem_data (mem_data), .flush (flush),
        .res_valid (res_valid), .res_data (res_data),
        .res_preg (res_preg), .res_rob (res_rob)
    );

    function automatic logic [ADDR_W-1:0] addr_of(int b, int i);
        return ADDR_W'(32'h1000 + b * 256 + i * 8);
    endfunction
    function automatic logic [PREG_W-1:0] preg_of(int b, int i);
        return PREG_W'((b * 8 + i) % 64);
    endfunction
    function automatic logic [ROB_W-1:0] rob_of(int b, int i);
        return ROB_W'((i * 3 + b) % 32);
    endfunction
    function automatic logic [DATA_W-1:0] data_of(int b, int i);
        return DATA_W'(32'hA5000000 ^ (b * 4099 + i * 77));
    endfunction

    task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic alloc_batch(input int b, input int n);
        for (int i = 0; i < n; i++) begin
            alloc_valid = 1'b1;
            alloc_addr  = addr_of(b, i);
            alloc_preg  = preg_of(b, i);
            alloc_rob   = rob_of(b, i);
            step();
        end
        alloc_valid = 1'b0;
    endtask

    task automatic serve(input int b, input int n, input bit last_chk);
        for (int i = 0; i < n; i++) begin
            chk(mem_req_valid == 1'b1, "R2 request present", 64'(mem_req_valid), 64'd1);
            chk(mem_req_addr == addr_of(b, i), "R2 request order", 64'(mem_req_addr), 64'(addr_of(b, i)));
            mem_resp_tag = '0;
            step();
            chk(mem_req_valid == 1'b1, "R3 retry valid", 64'(mem_req_valid), 64'd1);
            chk(mem_req_addr == addr_of(b, i), "R3 retry address", 64'(mem_req_addr), 64'(addr_of(b, i)));
            mem_resp_tag = MTAG_W'(i + 1);
            step();
            mem_resp_tag = '0;
        end
        if (last_chk)
            chk(mem_req_valid == 1'b0, "R10 no request left", 64'(mem_req_valid), 64'd0);
    endtask

    task automatic give_back(input int b, input int i);
        mem_data_tag = MTAG_W'(i + 1);
        mem_data     = data_of(b, i);
        step();
        mem_data_tag = '0;
        chk(res_valid == 1'b1, "R4 result valid", 64'(res_valid), 64'd1);
        chk(res_preg == preg_of(b, i), "R4 result preg", 64'(res_preg), 64'(preg_of(b, i)));
        chk(res_rob == rob_of(b, i), "R4 result rob", 64'(res_rob), 64'(rob_of(b, i)));
        chk(res_data == data_of(b, i), "R4 result data", 64'(res_data), 64'(data_of(b, i)));
        chk(lsq_one_load == 1'b1, "R9 one-load high", 64'(lsq_one_load), 64'd1);
    endtask

    initial begin
        rst_n = 1'b0; alloc_valid = 1'b0; alloc_addr = '0; alloc_preg = '0; alloc_rob = '0;
        mem_resp_tag = '0; mem_data_tag = '0; mem_data = '0; flush = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        step();
        chk(full == 1'b0, "R1 full after reset", 64'(full), 64'd0);
        chk(mem_req_valid == 1'b0, "R1 request after reset", 64'(mem_req_valid), 64'd0);
        chk(res_valid == 1'b0, "R1 result after reset", 64'(res_valid), 64'd0);
        chk(lsq_one_load == 1'b0, "R1 one-load after reset", 64'(lsq_one_load), 64'd0);

        // sweep of batch sizes, alternating return order, pointers wrap
        for (int b = 0; b < DEPTH; b++) begin
            int n;
            n = b + 1;
            alloc_batch(b, n);
            serve(b, n, 1'b1);
            for (int k = 0; k < n; k++) begin
                int i;
                i = (b % 2 == 0) ? (n - 1 - k) : k;
                give_back(b, i);
            end
            step();
            chk(res_valid == 1'b0, "R9 result drops", 64'(res_valid), 64'd0);
            chk(lsq_one_load == 1'b0, "R9 one-load low when idle", 64'(lsq_one_load), 64'd0);
            repeat (DEPTH + 1) step();
            chk(full == 1'b0, "R7 drained not full", 64'(full), 64'd0);
        end

        // full queue, dropped allocation, retire order
        alloc_batch(8, DEPTH);
        chk(full == 1'b1, "R6 full after DEPTH loads", 64'(full), 64'd1);
        alloc_valid = 1'b1; alloc_addr = 32'hDEAD0; alloc_preg = '0; alloc_rob = '0;
        step();
        alloc_valid = 1'b0;
        chk(full == 1'b1, "R6 still full", 64'(full), 64'd1);
        serve(8, DEPTH, 1'b1);
        give_back(8, DEPTH - 1);
        chk(full == 1'b1, "R7 full after youngest done", 64'(full), 64'd1);
        step();
        chk(full == 1'b1, "R7 full holds for youngest", 64'(full), 64'd1);
        give_back(8, 0);
        chk(full == 1'b1, "R7 full one edge after oldest", 64'(full), 64'd1);
        step();
        chk(full == 1'b0, "R7 full falls two edges after oldest", 64'(full), 64'd0);
        for (int i = 1; i < DEPTH - 1; i++) give_back(8, i);
        repeat (DEPTH + 1) step();
        chk(mem_req_valid == 1'b0, "R6 dropped load never requested", 64'(mem_req_valid), 64'd0);

        // stray and zero tags
        alloc_batch(9, 2);
        serve(9, 2, 1'b1);
        mem_data_tag = 4'd5; mem_data = 32'h12345678;
        step();
        mem_data_tag = '0;
        chk(res_valid == 1'b0, "R5 unmatched tag ignored", 64'(res_valid), 64'd0);
        step();
        chk(res_valid == 1'b0, "R5 zero tag ignored", 64'(res_valid), 64'd0);
        give_back(9, 1);
        give_back(9, 0);
        repeat (DEPTH + 1) step();

        // squash
        alloc_batch(10, 3);
        serve(10, 2, 1'b0);
        flush = 1'b1;
        step();
        flush = 1'b0;
        chk(mem_req_valid == 1'b0, "R8 no request after flush", 64'(mem_req_valid), 64'd0);
        chk(full == 1'b0, "R8 not full after flush", 64'(full), 64'd0);
        chk(res_valid == 1'b0, "R8 no result after flush", 64'(res_valid), 64'd0);
        mem_data_tag = 4'd1; mem_data = 32'hBAD;
        step();
        mem_data_tag = '0;
        chk(res_valid == 1'b0, "R8 late data squashed", 64'(res_valid), 64'd0);
        alloc_batch(11, 1);
        serve(11, 1, 1'b1);
        give_back(11, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule